// File: doc/BRIEF.md
# PLL coefficient search engine

This block finds the reference divider M, feedback multiplier N and post-divider code PL that bring a PLL's output closest to a requested frequency. A host pulses `start` with a requested rate and the reference frequency, both in kHz. The engine then steps through legal candidate combinations one at a time, scores each one, and reports the winning triple with a one-cycle `done` pulse. An `exact` flag tells the host whether the winner hits the target with zero error.

All quotients come from one shared bit-serial divider, so each division costs a fixed run of cycles. The divider table that maps a PL code to its post-divide ratio is not monotonic. Because of this, the outer loop visits ratios out of order, and a later code can yield a smaller error than an earlier one. The search stops early on the first zero-error candidate. It also prunes whole M or N ranges as soon as a limit is crossed.

Top module: `pll_coeff_search`

## Requirements
- R1: PL codes map to post-divide ratios as 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→10, 8→12, 9→16, 10→12, 11→16, 12→20, 13→24, 14→32. Code 15 maps to 1. `pl_out` is never above 14.
- R2: The reverse lookup scans codes 0 to 13 upward and returns the first one whose ratio is not below the asked ratio. If none matches it returns 14.
- R3: The internal target T is twice the requested rate. The headroom target is V0 = T + floor(T/50). The VCO window runs from 1,000,000 kHz up to max(2,064,000 kHz, V0).
- R4: The top PL code is the reverse lookup of ceil(window top / V0). The bottom PL code is the reverse lookup of floor(1,000,000 / V0). Each ratio is first clamped to the range 1..32. Codes are searched from bottom to top, and for each code the VCO goal is T times its ratio.
- R5: M runs upward from 1 to 255 with u = floor(ref/M). When u < 12,000 the M loop for that PL code ends. When u > 38,000 that M is skipped. `m_out` is never 0.
- R6: For each M, N runs from floor(goal·M/ref) to ceil(goal·M/ref). A floor value above 255 ends the M loop. N below 8 is skipped, and N above 255 ends the N loop. `n_out` is never below 8.
- R7: A candidate VCO = floor(ref·N/M) is accepted only inside the VCO window. Its error is |floor((VCO + ratio/2)/ratio) − T|.
- R8: A candidate becomes the best only when its error is strictly smaller than the best so far. A zero error ends the search at once and sets `exact`.
- R9: If no candidate is accepted, the result is M=255, N=8, PL code 1, and `exact` is 0.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle. The outputs then hold their values until the next result.
- R11: A start pulse while `busy` is high has no effect on the running search or its result.
- R12: A synchronous active-low reset returns the engine to idle with `busy`, `done`, `exact` and all result outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| rate_khz | input | 24 | Requested output rate in kHz, sampled on start |
| ref_khz | input | 20 | Reference frequency in kHz, sampled on start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, result valid |
| exact | output | 1 | Winning candidate had zero error |
| m_out | output | 8 | Chosen reference divider |
| n_out | output | 8 | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider code |

## Verification
The assertions take for granted that the requested rate is non-zero, so V0 is never zero and the window quotients are defined. They also assume the reference fits the 20-bit input. From the host they expect only single-cycle start pulses, with no other protocol. The directed stimulus keeps rates between 36,000 and 1,100,000 kHz and references between 10,000 and 38,400 kHz. Within that range every product fits the 40-bit datapath. The range also includes cases that visit the non-monotonic end of the ratio table, a case that exceeds the upper VCO bound, and a reference too slow for any M.

// File: rtl/pllsrch_pkg.sv
// Package: shared widths, state encoding and the PL-code/ratio functions.
// Assumes: codes are 4 bits, ratios fit in 6 bits (max 32).
package pllsrch_pkg;

    parameter int WORD_W  = 40;   // datapath width of all products/quotients
    parameter int CODE_W  = 4;    // PL code width
    parameter int RATIO_W = 6;    // post-divide ratio width
    parameter int NCODES  = 15;   // number of defined PL codes

    typedef enum logic [3:0] {
        ST_IDLE, ST_HEAD, ST_HI, ST_LO, ST_PL, ST_U,
        ST_N, ST_NCHK, ST_VCO, ST_OUT, ST_FIN
    } srch_state_t;

    // Ratio for a PL code; undefined codes give 1.
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:  return 6'd1;
            4'd1:  return 6'd2;
            4'd2:  return 6'd3;
            4'd3:  return 6'd4;
            4'd4:  return 6'd5;
            4'd5:  return 6'd6;
            4'd6:  return 6'd8;
            4'd7:  return 6'd10;
            4'd8:  return 6'd12;
            4'd9:  return 6'd16;
            4'd10: return 6'd12;
            4'd11: return 6'd16;
            4'd12: return 6'd20;
            4'd13: return 6'd24;
            4'd14: return 6'd32;
            default: return 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/pllsrch_plmap.sv
// Module: PL code to ratio lookup, plus the reverse lookup that returns the
// lowest code (0..NCODES-2) whose ratio reaches the request, else the last code.
// Assumes: purely combinational; ratio_in already clamped by the caller.
module pllsrch_plmap
    import pllsrch_pkg::*;
(
    input  logic [CODE_W-1:0]  code_in,
    output logic [RATIO_W-1:0] ratio_out,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [CODE_W-1:0]  code_out
);
    localparam int SCAN = NCODES - 1;

    logic [SCAN-1:0] reach;

    // forward lookup
    assign ratio_out = code_ratio(code_in);

    // one comparator per scanned code
    for (genvar g = 0; g < SCAN; g++) begin : g_cmp
        assign reach[g] = code_ratio(CODE_W'(g)) >= ratio_in;
    end

    // priority pick: lowest reaching code wins, default is the last code
    always_comb begin
        code_out = CODE_W'(SCAN);
        for (int i = SCAN - 1; i >= 0; i--) begin
            if (reach[i]) code_out = CODE_W'(i);
        end
    end

endmodule

// File: rtl/pllsrch_divider.sv
// Module: restoring bit-serial unsigned divider, one quotient bit per cycle.
// Assumes: start only when idle; operands sampled on start; done pulses one
// cycle after the last step and the results then hold until the next start.
// A zero divisor yields an all-ones quotient.
module pllsrch_divider #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     dvs;
    logic             run;
    logic [W:0]       trial;

    // shifted partial remainder for this step
    assign trial = {rem, quot[W-1]};

    // iterate one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dvs  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
            quot <= '0;
            rem  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quot <= dividend;
                rem  <= '0;
                dvs  <= divisor;
                cnt  <= CNT_W'(W);
                run  <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dvs}) begin
                    rem  <= W'(trial - {1'b0, dvs});
                    quot <= {quot[W-2:0], 1'b1};
                end else begin
                    rem  <= trial[W-1:0];
                    quot <= {quot[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pll_coeff_search.sv
// Module: sequential PLL coefficient search. Derives a PL window from VCO
// limits with 2% headroom, then walks PL, M and N, scoring one candidate per
// step through a shared serial divider and keeping the strictly best one.
// Assumes: rate_khz != 0; start is a single-cycle pulse and is ignored while
// busy; outputs are valid with done and held until the next result.
module pll_coeff_search
    import pllsrch_pkg::*;
#(
    parameter int RATE_W   = 24,
    parameter int REF_W    = 20,
    parameter int M_MIN    = 1,
    parameter int M_MAX    = 255,
    parameter int N_MIN    = 8,
    parameter int N_MAX    = 255,
    parameter int U_MIN    = 12000,
    parameter int U_MAX    = 38000,
    parameter int VCO_MIN  = 1000000,
    parameter int VCO_MAX  = 2064000,
    parameter int RAT_MIN  = 1,
    parameter int RAT_MAX  = 32,
    parameter int HEADROOM = 50,
    parameter int DEF_PL   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_khz,
    input  logic [REF_W-1:0]  ref_khz,
    output logic              busy,
    output logic              done,
    output logic              exact,
    output logic [7:0]        m_out,
    output logic [7:0]        n_out,
    output logic [3:0]        pl_out
);
    localparam int M_W = 8;
    localparam int N_W = 9;
    localparam logic [WORD_W-1:0] K_UMIN  = WORD_W'(U_MIN);
    localparam logic [WORD_W-1:0] K_UMAX  = WORD_W'(U_MAX);
    localparam logic [WORD_W-1:0] K_NMAXW = WORD_W'(N_MAX);
    localparam logic [N_W-1:0]    K_NMIN  = N_W'(N_MIN);
    localparam logic [N_W-1:0]    K_NMAX  = N_W'(N_MAX);
    localparam logic [WORD_W-1:0] K_VMIN  = WORD_W'(VCO_MIN);
    localparam logic [WORD_W-1:0] K_VMAX  = WORD_W'(VCO_MAX);
    localparam logic [WORD_W-1:0] K_RMIN  = WORD_W'(RAT_MIN);
    localparam logic [WORD_W-1:0] K_RMAX  = WORD_W'(RAT_MAX);
    localparam logic [WORD_W-1:0] K_HEAD  = WORD_W'(HEADROOM);
    localparam logic [M_W-1:0]    K_MMIN  = M_W'(M_MIN);
    localparam logic [M_W-1:0]    K_MMAX  = M_W'(M_MAX);

    srch_state_t         state;
    logic                launched;
    logic [WORD_W-1:0]   tgt, vt0, vmax, goal, vco, refv, best_err;
    logic [CODE_W-1:0]   pl_lo, pl_hi, pl_cur, best_pl;
    logic [M_W-1:0]      m_cur, best_m;
    logic [N_W-1:0]      n_cur, n_hi;
    logic [7:0]          best_n;

    logic                div_go, div_done, is_div;
    logic [WORD_W-1:0]   dvd, dvs, div_q, div_r, err, vt0_next;
    logic [RATIO_W-1:0]  ratio_cur, ratio_clamp;
    logic [CODE_W-1:0]   code_rev;
    logic                m_last, pl_last, vco_ok;

    // code/ratio tables
    pllsrch_plmap u_map (
        .code_in  (pl_cur),
        .ratio_out(ratio_cur),
        .ratio_in (ratio_clamp),
        .code_out (code_rev)
    );

    // shared quotient engine
    pllsrch_divider #(.W(WORD_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_go),
        .dividend(dvd),
        .divisor (dvs),
        .done    (div_done),
        .quot    (div_q),
        .rem     (div_r)
    );

    // clamp the latest quotient into the legal ratio range
    assign ratio_clamp = (div_q < K_RMIN) ? RATIO_W'(RAT_MIN) :
                         (div_q > K_RMAX) ? RATIO_W'(RAT_MAX) : div_q[RATIO_W-1:0];

    // loop-end tests and helper values
    assign m_last   = (m_cur == K_MMAX);
    assign pl_last  = (pl_cur == pl_hi);
    assign vco_ok   = (div_q >= K_VMIN) && (div_q <= vmax);
    assign err      = (div_q > tgt) ? (div_q - tgt) : (tgt - div_q);
    assign vt0_next = tgt + div_q;
    assign busy     = (state != ST_IDLE);

    // operand selection per dividing state
    always_comb begin
        is_div = 1'b1;
        dvd    = '0;
        dvs    = WORD_W'(1);
        case (state)
            ST_HEAD: begin dvd = tgt;                    dvs = K_HEAD;              end
            ST_HI:   begin dvd = vmax + vt0 - 1'b1;      dvs = vt0;                 end
            ST_LO:   begin dvd = K_VMIN;                 dvs = vt0;                 end
            ST_U:    begin dvd = refv;                   dvs = WORD_W'(m_cur);      end
            ST_N:    begin dvd = goal * WORD_W'(m_cur);  dvs = refv;                end
            ST_VCO:  begin dvd = refv * WORD_W'(n_cur);  dvs = WORD_W'(m_cur);      end
            ST_OUT:  begin dvd = vco + WORD_W'(ratio_cur >> 1); dvs = WORD_W'(ratio_cur); end
            default: is_div = 1'b0;
        endcase
        div_go = is_div && !launched;
    end

    // search sequencer and best-candidate tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  launched <= 1'b0;
            tgt <= '0; vt0 <= '0; vmax <= '0; goal <= '0; vco <= '0; refv <= '0;
            pl_lo <= '0; pl_hi <= '0; pl_cur <= '0; m_cur <= '0;
            n_cur <= '0; n_hi <= '0;
            best_m <= '0; best_n <= '0; best_pl <= '0; best_err <= '0;
            done <= 1'b0; exact <= 1'b0;
            m_out <= '0; n_out <= '0; pl_out <= '0;
        end else begin
            done <= 1'b0;
            if (div_go) launched <= 1'b1;
            if (div_done) launched <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    tgt      <= WORD_W'(rate_khz) << 1;
                    refv     <= WORD_W'(ref_khz);
                    best_m   <= K_MMAX;
                    best_n   <= 8'(N_MIN);
                    best_pl  <= CODE_W'(DEF_PL);
                    best_err <= '1;
                    state    <= ST_HEAD;
                end
                ST_HEAD: if (div_done) begin
                    vt0   <= vt0_next;
                    vmax  <= (vt0_next > K_VMAX) ? vt0_next : K_VMAX;
                    state <= ST_HI;
                end
                ST_HI: if (div_done) begin
                    pl_hi <= code_rev;
                    state <= ST_LO;
                end
                ST_LO: if (div_done) begin
                    pl_lo  <= code_rev;
                    pl_cur <= code_rev;
                    state  <= (code_rev > pl_hi) ? ST_FIN : ST_PL;
                end
                ST_PL: begin
                    goal  <= tgt * WORD_W'(ratio_cur);
                    m_cur <= K_MMIN;
                    state <= ST_U;
                end
                ST_U: if (div_done) begin
                    if (div_q < K_UMIN) begin
                        pl_cur <= pl_cur + 1'b1;
                        state  <= pl_last ? ST_FIN : ST_PL;
                    end else if (div_q > K_UMAX) begin
                        if (m_last) begin
                            pl_cur <= pl_cur + 1'b1;
                            state  <= pl_last ? ST_FIN : ST_PL;
                        end else begin
                            m_cur <= m_cur + 1'b1;
                            state <= ST_U;
                        end
                    end else begin
                        state <= ST_N;
                    end
                end
                ST_N: if (div_done) begin
                    if (div_q > K_NMAXW) begin
                        pl_cur <= pl_cur + 1'b1;
                        state  <= pl_last ? ST_FIN : ST_PL;
                    end else begin
                        n_cur <= div_q[N_W-1:0];
                        n_hi  <= div_q[N_W-1:0] + N_W'(div_r != '0);
                        state <= ST_NCHK;
                    end
                end
                ST_NCHK: begin
                    if (n_cur > n_hi || n_cur > K_NMAX) begin
                        if (m_last) begin
                            pl_cur <= pl_cur + 1'b1;
                            state  <= pl_last ? ST_FIN : ST_PL;
                        end else begin
                            m_cur <= m_cur + 1'b1;
                            state <= ST_U;
                        end
                    end else if (n_cur < K_NMIN) begin
                        n_cur <= n_cur + 1'b1;
                    end else begin
                        state <= ST_VCO;
                    end
                end
                ST_VCO: if (div_done) begin
                    if (vco_ok) begin
                        vco   <= div_q;
                        state <= ST_OUT;
                    end else begin
                        n_cur <= n_cur + 1'b1;
                        state <= ST_NCHK;
                    end
                end
                ST_OUT: if (div_done) begin
                    if (err < best_err) begin
                        best_err <= err;
                        best_m   <= m_cur;
                        best_n   <= n_cur[7:0];
                        best_pl  <= pl_cur;
                    end
                    if (err == '0) begin
                        state <= ST_FIN;
                    end else begin
                        n_cur <= n_cur + 1'b1;
                        state <= ST_NCHK;
                    end
                end
                ST_FIN: begin
                    done   <= 1'b1;
                    exact  <= (best_err == '0);
                    m_out  <= best_m;
                    n_out  <= best_n;
                    pl_out <= best_pl;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pllsrch_checker.sv
// Module: protocol and range checks for pll_coeff_search, bound to the top.
// Assumes: observes top-level ports only.
module pllsrch_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] m_out,
    input logic [7:0] n_out,
    input logic [3:0] pl_out
);
    // done is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // a result only follows a busy period
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // results hold while idle
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out)));

    // an idle start launches a search
    assert_start_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // reported code is a defined one
    assert_pl_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pl_out <= 4'd14));

    // reported M is non-zero
    assert_m_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (m_out != 8'd0));

    // reported N is not below its minimum
    assert_n_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_out >= 8'd8));

    // reset leaves the engine idle
    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

endmodule

bind pll_coeff_search pllsrch_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .m_out (m_out),
    .n_out (n_out),
    .pl_out(pl_out)
);

// File: tb/test_pll_coeff_search.sv
module test_pll_coeff_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] rate_khz = '0;
    logic [19:0] ref_khz = '0;
    logic        busy, done, exact;
    logic [7:0]  m_out, n_out;
    logic [3:0]  pl_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_coeff_search i_pll_coeff_search (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rate_khz(rate_khz), .ref_khz(ref_khz),
        .busy(busy), .done(done), .exact(exact),
        .m_out(m_out), .n_out(n_out), .pl_out(pl_out)
    );

    // ---------- reference model from the requirements ----------
    function automatic longint ratio_of(input int code);
        case (code)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; 14: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic int code_of(input longint r);
        for (int c = 0; c < 14; c++) if (ratio_of(c) >= r) return c;
        return 14;
    endfunction

    function automatic longint clamp_r(input longint r);
        if (r < 1) return 1;
        if (r > 32) return 32;
        return r;
    endfunction

    task automatic model(input longint rate, input longint rf,
                         output int em, output int en, output int epl, output bit eex);
        longint t, v0, vmx, best;
        int hp, lp;
        bit stop;
        t    = rate * 2;
        v0   = t + t / 50;
        vmx  = (v0 > 2064000) ? v0 : 2064000;
        hp   = code_of(clamp_r((vmx + v0 - 1) / v0));
        lp   = code_of(clamp_r(1000000 / v0));
        best = 64'h7fff_ffff_ffff_ffff;
        em = 255; en = 8; epl = 1; stop = 0;
        for (int pl = lp; pl <= hp && !stop; pl++) begin
            longint d, g;
            d = ratio_of(pl);
            g = t * d;
            for (int m = 1; m <= 255 && !stop; m++) begin
                longint u, nl, nh;
                u = rf / m;
                if (u < 12000) break;
                if (u > 38000) continue;
                nl = g * m / rf;
                nh = (g * m + rf - 1) / rf;
                if (nl > 255) break;
                for (longint n = nl; n <= nh && !stop; n++) begin
                    longint vco, lw, e;
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = rf * n / m;
                    if (vco >= 1000000 && vco <= vmx) begin
                        lw = (vco + d / 2) / d;
                        e  = (lw > t) ? lw - t : t - lw;
                        if (e < best) begin
                            best = e; em = m; en = int'(n); epl = pl;
                            if (e == 0) stop = 1;
                        end
                    end
                end
            end
        end
        eex = (best == 0);
    endtask

    // ---------- helpers ----------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input longint rate, input longint rf);
        @(negedge clk);
        rate_khz = 24'(rate);
        ref_khz  = 20'(rf);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 40000; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check(got, "R10", "done seen before timeout", got, 1);
    endtask

    task automatic run_and_compare(input longint rate, input longint rf, input string req);
        int em, en, epl;
        bit eex, got;
        model(rate, rf, em, en, epl, eex);
        pulse_start(rate, rf);
        check(busy == 1'b1, "R10", "busy after start", busy, 1);
        wait_done(got);
        if (got) begin
            check(m_out == em,   req, "m_out",  m_out,  em);
            check(n_out == en,   req, "n_out",  n_out,  en);
            check(pl_out == epl, req, "pl_out", pl_out, epl);
            check(exact == eex,  req, "exact",  exact,  eex);
        end
    endtask

    // ---------- scenarios ----------
    task automatic t_reset_state;
        check(busy == 0,   "R12", "busy in reset",  busy,   0);
        check(done == 0,   "R12", "done in reset",  done,   0);
        check(exact == 0,  "R12", "exact in reset", exact,  0);
        check(m_out == 0,  "R12", "m_out in reset", m_out,  0);
        check(n_out == 0,  "R12", "n_out in reset", n_out,  0);
        check(pl_out == 0, "R12", "pl in reset",    pl_out, 0);
    endtask

    task automatic t_known_exact;
        // R8: 72 MHz from 12 MHz hits zero error at M=1, N=96, code 6
        bit got;
        pulse_start(72000, 12000);
        wait_done(got);
        check(m_out == 1,  "R8", "exact case m",  m_out,  1);
        check(n_out == 96, "R8", "exact case n",  n_out,  96);
        check(pl_out == 6, "R8", "exact case pl", pl_out, 6);
        check(exact == 1,  "R8", "exact flag",    exact,  1);
    endtask

    task automatic t_sweep;
        run_and_compare(36000,   12000, "R1");   // window spans codes 9..14, non-monotonic ratios
        run_and_compare(36000,   19200, "R2");
        run_and_compare(500000,  19200, "R3");
        run_and_compare(1000000, 12000, "R4");   // window collapses to codes 0..1
        run_and_compare(1100000, 38400, "R3");   // headroom target above upper VCO bound
        run_and_compare(250000,  38400, "R5");   // M=1 skipped, M>=2 used
        run_and_compare(333333,  13000, "R6");
        run_and_compare(123457,  19200, "R7");
        run_and_compare(612000,  12800, "R8");
    endtask

    task automatic t_default;
        // R9: reference below the u floor even at M=1
        bit got;
        pulse_start(100000, 10000);
        wait_done(got);
        check(m_out == 255, "R9", "default m",  m_out,  255);
        check(n_out == 8,   "R9", "default n",  n_out,  8);
        check(pl_out == 1,  "R9", "default pl", pl_out, 1);
        check(exact == 0,   "R9", "default exact", exact, 0);
    endtask

    task automatic t_pulse_and_hold;
        bit got;
        logic [7:0] m0, n0;
        logic [3:0] p0;
        pulse_start(180000, 19200);
        wait_done(got);
        m0 = m_out; n0 = n_out; p0 = pl_out;
        @(negedge clk);
        check(done == 0, "R10", "done width one cycle", done, 0);
        check(busy == 0, "R10", "idle after done", busy, 0);
        repeat (10) @(negedge clk);
        check({m_out, n_out, pl_out} == {m0, n0, p0}, "R10", "result held",
              {m_out, n_out, pl_out}, {m0, n0, p0});
    endtask

    task automatic t_ignore_start;
        int em, en, epl;
        bit eex, got;
        model(72000, 12000, em, en, epl, eex);
        pulse_start(72000, 12000);
        repeat (20) @(negedge clk);
        pulse_start(500000, 19200);   // R11: arrives mid-search
        wait_done(got);
        check(m_out == em,   "R11", "m after ignored start",  m_out,  em);
        check(n_out == en,   "R11", "n after ignored start",  n_out,  en);
        check(pl_out == epl, "R11", "pl after ignored start", pl_out, epl);
        @(negedge clk);
        check(busy == 0, "R11", "no second search", busy, 0);
    endtask

    task automatic t_reset_midrun;
        pulse_start(36000, 12000);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 0,  "R12", "busy after mid reset",  busy,  0);
        check(done == 0,  "R12", "done after mid reset",  done,  0);
        check(m_out == 0, "R12", "m after mid reset",     m_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_and_compare(252000, 12000, "R12");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual not finished expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_known_exact();
        t_sweep();
        t_default();
        t_pulse_and_hold();
        t_ignore_start();
        t_reset_midrun();
        finish_run();
    end

endmodule